// File: doc/BRIEF.md
# Two-Pass Subranging Conversion Sequencer

This block runs one 16-bit conversion as two passes. After a start pulse it holds the sample-and-hold in sample mode for a fixed settling interval. It then waits for the coarse 8-bit flash result, captures it, and strobes it into the upper byte of the reconstruction DAC. The external analog path subtracts that estimate from the held input and multiplies the residue by 256.

After a second settling interval the block waits for the 9-bit fine flash result. The fine code carries one redundant bit of overlap. A mid-scale offset of 128 is removed from it, and it is added to the coarse byte placed in the upper eight bits. This repairs a coarse pass that landed one step high or low. The corrected word is clipped to the 16-bit range and loaded into the result register, and a one-cycle done flag marks the load.

Both settling intervals are given in nanoseconds and turned into clock-cycle counts from a clock-frequency parameter. The analog stages, the flash converters and the DAC are all outside the block.

Top module: `subrange_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it, `sh_sample`, `dac_load` and `done` are 0, and `dac_code` and `result` are 0.
- R2: A `start` seen high at a clock edge while idle raises `sh_sample` in the next cycle. It stays high for exactly SAMPLE_CYC = CLK_MHZ*SAMPLE_NS/1000 cycles, with a minimum of 1.
- R3: `coarse_code` is captured at the first clock edge after the sampling interval at which `coarse_rdy` is high. A `coarse_rdy` that is high during sampling causes no capture before that edge.
- R4: In the cycle after the coarse capture, `dac_load` is high for exactly one cycle and `dac_code` equals the captured coarse code. `dac_code` holds that value until the next conversion's load.
- R5: `fine_code` is captured at the first edge at which `fine_rdy` is high, once SETTLE_CYC = CLK_MHZ*SETTLE_NS/1000 cycles (minimum 1) have passed after the `dac_load` cycle. If `fine_rdy` is already high, `done` follows the `dac_load` cycle by SETTLE_CYC+3 cycles.
- R6: `result` = coarse*256 + fine − 128. Here fine is the 9-bit unsigned fine code, and fine = 128 means no correction.
- R7: A sum below 0 gives `result` = 0x0000, and a sum above 65535 gives `result` = 0xFFFF.
- R8: `done` is high for exactly one cycle, two cycles after the fine capture edge. `result` takes its new value in that same cycle and does not change in any other cycle.
- R9: A `start` seen while a conversion is in progress is ignored. Sampling is neither restarted nor extended, and no extra conversion follows.
- R10: `sh_sample` and `dac_load` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one conversion |
| coarse_code | input | 8 | Coarse flash result |
| coarse_rdy | input | 1 | Coarse flash result valid |
| fine_code | input | 9 | Fine flash result with overlap bit |
| fine_rdy | input | 1 | Fine flash result valid |
| sh_sample | output | 1 | High: sample-and-hold tracks; low: holds |
| dac_load | output | 1 | One-cycle latch strobe for the DAC upper byte |
| dac_code | output | 8 | Coarse estimate driven to the DAC upper byte |
| done | output | 1 | One-cycle pulse when `result` updates |
| result | output | 16 | Corrected conversion word |

## Verification
Sampling begins the cycle after `start`, and the bench counts `sh_sample` high cycles against SAMPLE_CYC. `dac_load` with the coarse code on `dac_code` is due one cycle after the coarse capture edge, and is checked in exactly that cycle. With `fine_rdy` raised early, `done` is due SETTLE_CYC+3 cycles after the `dac_load` cycle, and the bench counts the cycles between the two. Each expected word goes into a queue when its conversion is launched and is popped and compared in the cycle `done` is seen. Every sample is taken on the falling edge, half a period after the register it depends on.

// File: rtl/subrange_pkg.sv
// Shared types for the subranging conversion sequencer.
// Assumes: one conversion at a time; states are listed in visiting order.
package subrange_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_FLASH1,
        ST_LOAD_DAC,
        ST_SETTLE,
        ST_FLASH2,
        ST_CORRECT,
        ST_DONE
    } sr_state_t;

endpackage

// File: rtl/sr_interval_timer.sv
// Down-counter for fixed settling waits.
// A load sets the count to load_val; expired is high when the count is zero.
// Assumes: the owner loads value N-1 to get an interval of N cycles.
module sr_interval_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt;

    // Load on request, otherwise count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R2
    timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/sr_fine_correct.sv
// Joins the coarse and fine flash codes into one word.
// The fine code carries one overlap bit, so its mid-scale (2**(FW-2)) means
// no correction. The sum is clipped to the output range.
// Assumes: FW == OW - CW + 1.
module sr_fine_correct #(
    parameter int CW = 8,
    parameter int FW = 9,
    parameter int OW = 16
) (
    input  logic [CW-1:0] coarse,
    input  logic [FW-1:0] fine,
    output logic [OW-1:0] word
);

    localparam int SW = OW + 2;
    localparam logic signed [SW-1:0] OFFSET = SW'(2 ** (FW - 2));

    logic signed [SW-1:0] sum;

    // Offset-corrected sum, then clip at both ends of the range.
    always_comb begin
        sum = $signed({2'b00, coarse, {(OW-CW){1'b0}}})
            + $signed({{(SW-FW){1'b0}}, fine})
            - OFFSET;
        if (sum[SW-1])
            word = '0;
        else if (sum[SW-2])
            word = '1;
        else
            word = sum[OW-1:0];
    end

endmodule

// File: rtl/subrange_seq.sv
// Sequencer for a two-pass subranging conversion.
// Order of work: sample, wait for the coarse flash, strobe the coarse code to
// the DAC, settle, wait for the fine flash, correct, then raise done for one
// cycle. Start is taken only while idle.
// Assumes: flash ready inputs are synchronous to clk; the analog path is
// external.
module subrange_seq #(
    parameter int CLK_MHZ   = 100,
    parameter int SAMPLE_NS = 5000,
    parameter int SETTLE_NS = 2000,
    parameter int CW        = 8,
    parameter int FW        = 9,
    parameter int OW        = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] coarse_code,
    input  logic          coarse_rdy,
    input  logic [FW-1:0] fine_code,
    input  logic          fine_rdy,
    output logic          sh_sample,
    output logic          dac_load,
    output logic [CW-1:0] dac_code,
    output logic          done,
    output logic [OW-1:0] result
);

    import subrange_pkg::*;

    localparam int SAMPLE_RAW = (CLK_MHZ * SAMPLE_NS) / 1000;
    localparam int SETTLE_RAW = (CLK_MHZ * SETTLE_NS) / 1000;
    localparam int SAMPLE_CYC = (SAMPLE_RAW < 1) ? 1 : SAMPLE_RAW;
    localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam int MAX_CYC    = (SAMPLE_CYC > SETTLE_CYC) ? SAMPLE_CYC : SETTLE_CYC;
    localparam int TW         = $clog2(MAX_CYC + 1);

    sr_state_t     state, state_nx;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    logic [FW-1:0] fine_q;
    logic [OW-1:0] corr_word;

    // Next-state choice from the current phase and its wait condition.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start)       state_nx = ST_SAMPLE;
            ST_SAMPLE:   if (tmr_expired) state_nx = ST_FLASH1;
            ST_FLASH1:   if (coarse_rdy)  state_nx = ST_LOAD_DAC;
            ST_LOAD_DAC:                  state_nx = ST_SETTLE;
            ST_SETTLE:   if (tmr_expired) state_nx = ST_FLASH2;
            ST_FLASH2:   if (fine_rdy)    state_nx = ST_CORRECT;
            ST_CORRECT:                   state_nx = ST_DONE;
            ST_DONE:                      state_nx = ST_IDLE;
            default:                      state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Timer reload on entry to either settling phase.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state == ST_IDLE && start) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(SAMPLE_CYC - 1);
        end else if (state == ST_LOAD_DAC) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(SETTLE_CYC - 1);
        end
    end

    sr_interval_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Capture the coarse code; it also drives the DAC upper byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dac_code <= '0;
        else if (state == ST_FLASH1 && coarse_rdy)
            dac_code <= coarse_code;
    end

    // Capture the fine code once the residue has settled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fine_q <= '0;
        else if (state == ST_FLASH2 && fine_rdy)
            fine_q <= fine_code;
    end

    sr_fine_correct #(.CW(CW), .FW(FW), .OW(OW)) u_corr (
        .coarse (dac_code),
        .fine   (fine_q),
        .word   (corr_word)
    );

    // Output register, loaded once per conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (state == ST_CORRECT)
            result <= corr_word;
    end

    assign sh_sample = (state == ST_SAMPLE);
    assign dac_load  = (state == ST_LOAD_DAC);
    assign done      = (state == ST_DONE);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R4
    dac_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |=> !dac_load);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_sample && dac_load));

    // R9
    sample_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_sample) |-> $past(state == ST_IDLE));

endmodule

// File: tb/tb_subrange_seq.sv
module tb_subrange_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 2;
    localparam int SAMPLE_NS  = 5000;
    localparam int SETTLE_NS  = 2000;
    localparam int SAMPLE_CYC = CLK_MHZ * SAMPLE_NS / 1000;
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_NS / 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  coarse_code = '0;
    logic        coarse_rdy = 1'b0;
    logic [8:0]  fine_code = '0;
    logic        fine_rdy = 1'b0;
    logic        sh_sample, dac_load, done;
    logic [7:0]  dac_code;
    logic [15:0] result;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [15:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    subrange_seq #(.CLK_MHZ(CLK_MHZ), .SAMPLE_NS(SAMPLE_NS), .SETTLE_NS(SETTLE_NS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .coarse_code(coarse_code), .coarse_rdy(coarse_rdy),
        .fine_code(fine_code), .fine_rdy(fine_rdy),
        .sh_sample(sh_sample), .dac_load(dac_load), .dac_code(dac_code),
        .done(done), .result(result)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input int c, input int f);
        int s = c * 256 + f - 128;
        if (s < 0) return 16'h0000;
        if (s > 65535) return 16'hFFFF;
        return s[15:0];
    endfunction

    // Monitor: pop and compare an expected word whenever done is seen.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected done", 1, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check("R6/R7 result", result, e);
            end
        end
    end

    // Driver: one conversion with optional coarse delay, early ready and busy start.
    task automatic convert(input int c, input int f, input int cdly,
                           input bit early_c, input bit busy);
        int n;
        int k;
        exp_q.push_back(model(c, f));
        if (early_c) begin
            coarse_code = c[7:0];
            coarse_rdy  = 1'b1;
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 0;
        while (sh_sample && n < 1000) begin
            n++;
            start = (busy && n == 3);
            @(negedge clk);
        end
        start = 1'b0;
        check("R2/R9 sample length", n, SAMPLE_CYC);
        if (!early_c) begin
            for (int i = 0; i < cdly; i++) @(negedge clk);
            coarse_code = c[7:0];
            coarse_rdy  = 1'b1;
        end
        @(negedge clk);
        coarse_rdy = 1'b0;
        coarse_code = ~c[7:0];
        check("R4 dac_load", dac_load, 1);
        check("R3/R4 dac_code", dac_code, c);
        fine_code = f[8:0];
        fine_rdy  = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!done && k < 1000);
        check("R5 done latency", k, SETTLE_CYC + 3);
        fine_rdy = 1'b0;
        @(negedge clk);
        check("R8 done single cycle", done, 0);
        check("R4 dac_code held", dac_code, c);
        if (busy) begin
            for (int i = 0; i < 5; i++) begin
                check("R9 no restart", sh_sample, 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 sh_sample", sh_sample, 0);
        check("R1 dac_load", dac_load, 0);
        check("R1 done", done, 0);
        check("R1 result", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 dac_code", dac_code, 0);
        check("R1 done after reset", done, 0);
        convert(8'h12, 128, 0, 0, 0);
        convert(8'h80, 0,   2, 0, 0);
        convert(8'h7F, 300, 0, 1, 0);
        convert(8'hA5, 384, 5, 0, 1);
        convert(8'h00, 200, 1, 0, 0);
        convert(8'h00, 0,   0, 0, 0);   // R7 low clip
        convert(8'hFF, 511, 0, 1, 0);   // R7 high clip
        convert(8'hFF, 255, 3, 0, 0);
        repeat (3) @(negedge clk);
        check("R9 queue drained", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule